// File: doc/BRIEF.md
# Circular First-Live Egress Port Picker

This block chooses the egress port for a packet on a switch with `NUM_PORTS` ports when the preferred port may have failed. The caller presents a preferred start port (a 1-based index) together with a liveness vector that has one bit per port, and raises a request strobe. The block returns the first live port found by walking upward from the start port and wrapping from the highest port back to port 1. It also returns a found flag, and it raises a response strobe exactly one clock after the request.

The search takes a single parallel step. The start index is widened into a window mask of `2*NUM_PORTS-1` bits. Bits 0 to `NUM_PORTS-1` stand for ports 1 to `NUM_PORTS`. The upper `NUM_PORTS-1` bits stand for ports 1 to `NUM_PORTS-1` a second time. For start port p, window bits p-1 through p+NUM_PORTS-2 are set. Each window bit is ANDed with the liveness bit of the port it stands for, and the lowest-numbered bit that hits gives the result. Wrap-around is therefore handled without a second pass. The number of failed ports has no effect on timing.

Top module: `circ_port_pick`

## Requirements
- R1: While reset is asserted (`rst_n` low) and after it is released, `rspValid`, `pickFound` and `pickPort` are all 0 until the first request.
- R2: `rspValid` is 1 in exactly the cycle after a cycle in which `reqValid` was 1, so consecutive requests give consecutive responses.
- R3: If the start port p (1..NUM_PORTS) is live, meaning `liveMask[p-1]` is 1, the response gives `pickFound`=1 and `pickPort`=p.
- R4: If the start port is in range but failed, the response gives the first live port among p+1 .. NUM_PORTS, then 1 .. p-1, in that order, with `pickFound`=1.
- R5: If the start port is in range and no port is live, the response gives `pickFound`=0 and `pickPort`=0.
- R6: If the start index is 0 or greater than NUM_PORTS, the response gives `pickFound`=0 and `pickPort`=0, whatever the liveness vector holds.
- R7: The response latency is one clock for every liveness pattern, no matter how many ports have failed.
- R8: In cycles without a request, `pickPort` and `pickFound` keep the values of the last response, whatever changes on `startPort` and `liveMask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| startPort | input | $clog2(NUM_PORTS+1) | Preferred start port, 1-based |
| liveMask | input | NUM_PORTS | Bit i is 1 when port i+1 is active |
| rspValid | output | 1 | Response strobe, one clock after the request |
| pickPort | output | $clog2(NUM_PORTS+1) | Selected port, 1-based; 0 when none is found |
| pickFound | output | 1 | 1 when a live port was selected |

## Verification
Every result is due one rising edge after its request is sampled. The bench drives inputs on falling edges. It checks each response on the next falling edge, in the same step in which it drives the following request, so the sweep over all start indices and liveness patterns runs back to back. The hold behaviour is checked over idle cycles that follow a response. During those cycles the bench changes the inputs and confirms that the outputs do not move.

// File: rtl/cpp_pkg.sv
package cpp_pkg;
  typedef struct packed {
    logic load;
  } ctrlStrobes_t;
endpackage

// File: rtl/cpp_window.sv
module cpp_window #(
  parameter int NUM_PORTS = 4,
  localparam int IDX_W = $clog2(NUM_PORTS + 1),
  localparam int WIN_W = 2 * NUM_PORTS - 1
) (
  input  logic [IDX_W-1:0] startIdx,
  output logic [WIN_W-1:0] winMask
);
  logic inRange;
  int   startInt;

  always_comb begin
    startInt = int'(startIdx);
    inRange  = (startInt >= 1) && (startInt <= NUM_PORTS);
  end

  // Window bits p-1 .. p+NUM_PORTS-2 are set for start port p.
  for (genvar j = 0; j < WIN_W; j++) begin : g_win
    assign winMask[j] = inRange && (j >= startInt - 1) && (j <= startInt + NUM_PORTS - 2);
  end
endmodule

// File: rtl/cpp_match.sv
module cpp_match #(
  parameter int NUM_PORTS = 4,
  localparam int IDX_W = $clog2(NUM_PORTS + 1),
  localparam int WIN_W = 2 * NUM_PORTS - 1
) (
  input  logic [WIN_W-1:0]     winMask,
  input  logic [NUM_PORTS-1:0] liveMask,
  output logic                 hitFound,
  output logic [IDX_W-1:0]     hitPort
);
  logic [WIN_W-1:0] hitVec;

  for (genvar j = 0; j < WIN_W; j++) begin : g_hit
    assign hitVec[j] = winMask[j] & liveMask[j % NUM_PORTS];
  end

  // Lowest window index has priority: scan downward so the last write wins.
  always_comb begin
    hitFound = 1'b0;
    hitPort  = '0;
    for (int j = WIN_W - 1; j >= 0; j--) begin
      if (hitVec[j]) begin
        hitFound = 1'b1;
        hitPort  = IDX_W'((j % NUM_PORTS) + 1);
      end
    end
  end
endmodule

// File: rtl/cpp_ctrl.sv
module cpp_ctrl
  import cpp_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  output ctrlStrobes_t strobes,
  output logic         rspValid
);
  always_comb strobes.load = reqValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rspValid <= 1'b0;
    else        rspValid <= reqValid;
  end
endmodule

// File: rtl/cpp_datapath.sv
module cpp_datapath
  import cpp_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int IDX_W = $clog2(NUM_PORTS + 1),
  localparam int WIN_W = 2 * NUM_PORTS - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrlStrobes_t         strobes,
  input  logic [IDX_W-1:0]     startPort,
  input  logic [NUM_PORTS-1:0] liveMask,
  output logic [IDX_W-1:0]     pickPort,
  output logic                 pickFound
);
  logic [WIN_W-1:0] winMask;
  logic             hitFound;
  logic [IDX_W-1:0] hitPort;

  cpp_window #(.NUM_PORTS(NUM_PORTS)) u_window (
    .startIdx(startPort),
    .winMask (winMask)
  );

  cpp_match #(.NUM_PORTS(NUM_PORTS)) u_match (
    .winMask (winMask),
    .liveMask(liveMask),
    .hitFound(hitFound),
    .hitPort (hitPort)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pickPort  <= '0;
      pickFound <= 1'b0;
    end else if (strobes.load) begin
      pickPort  <= hitPort;
      pickFound <= hitFound;
    end
  end
endmodule

// File: rtl/circ_port_pick.sv
module circ_port_pick
  import cpp_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int IDX_W = $clog2(NUM_PORTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reqValid,
  input  logic [IDX_W-1:0]     startPort,
  input  logic [NUM_PORTS-1:0] liveMask,
  output logic                 rspValid,
  output logic [IDX_W-1:0]     pickPort,
  output logic                 pickFound
);
  ctrlStrobes_t strobes;

  cpp_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .reqValid(reqValid),
    .strobes (strobes),
    .rspValid(rspValid)
  );

  cpp_datapath #(.NUM_PORTS(NUM_PORTS)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .startPort(startPort),
    .liveMask (liveMask),
    .pickPort (pickPort),
    .pickFound(pickFound)
  );
endmodule

// File: rtl/circ_port_pick_chk.sv
module circ_port_pick_chk #(
  parameter int NUM_PORTS = 4,
  localparam int IDX_W = $clog2(NUM_PORTS + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reqValid,
  input logic [IDX_W-1:0]     startPort,
  input logic [NUM_PORTS-1:0] liveMask,
  input logic                 rspValid,
  input logic [IDX_W-1:0]     pickPort,
  input logic                 pickFound
);
  logic [NUM_PORTS-1:0] lastLive;
  logic [IDX_W-1:0]     lastStart;
  logic                 pickIsLive;
  logic                 startInRange;
  logic                 startWasLive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastLive  <= '0;
      lastStart <= '0;
    end else if (reqValid) begin
      lastLive  <= liveMask;
      lastStart <= startPort;
    end
  end

  always_comb begin
    pickIsLive   = 1'b0;
    startWasLive = 1'b0;
    startInRange = (int'(lastStart) >= 1) && (int'(lastStart) <= NUM_PORTS);
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (int'(pickPort) == i + 1 && lastLive[i])  pickIsLive   = 1'b1;
      if (int'(lastStart) == i + 1 && lastLive[i]) startWasLive = 1'b1;
    end
  end

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);
  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspValid);
  assert_live_start_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && startInRange && startWasLive) |-> (pickFound && pickPort == lastStart));
  assert_pick_is_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && pickFound) |-> pickIsLive);
  assert_none_port_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pickFound |-> (pickPort == '0));
  assert_bad_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && !startInRange) |-> !pickFound);
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rspValid |-> ($stable(pickPort) && $stable(pickFound)));
endmodule

bind circ_port_pick circ_port_pick_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reqValid (reqValid),
  .startPort(startPort),
  .liveMask (liveMask),
  .rspValid (rspValid),
  .pickPort (pickPort),
  .pickFound(pickFound)
);

// File: tb/circ_port_pick_tb.sv
`timescale 1ns/1ps
module circ_port_pick_tb;
  localparam int K = 4;
  localparam int IW = $clog2(K + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reqValid = 1'b0;
  logic [IW-1:0] startPort = '0;
  logic [K-1:0]  liveMask = '0;
  logic          rspValid;
  logic [IW-1:0] pickPort;
  logic          pickFound;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  circ_port_pick #(.NUM_PORTS(K)) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .startPort(startPort),
    .liveMask(liveMask), .rspValid(rspValid), .pickPort(pickPort), .pickFound(pickFound)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Returns expected port, 0 when none; also the requirement class.
  function automatic int refPick(input int s, input int live, output string req);
    if (s < 1 || s > K) begin req = "R6"; return 0; end
    if (live[s-1]) begin req = "R3"; return s; end
    req = (live == 0) ? "R5" : "R4";
    for (int o = 1; o < K; o++) begin
      int q = ((s - 1 + o) % K) + 1;
      if (live[q-1]) return q;
    end
    return 0;
  endfunction

  task automatic checkRsp(input int s, input int live);
    string req;
    int exp;
    exp = refPick(s, live, req);
    chk("R2 R7 rspValid", int'(rspValid), 1);
    chk({req, " pickPort"}, int'(pickPort), exp);
    chk({req, " pickFound"}, int'(pickFound), (exp != 0) ? 1 : 0);
  endtask

  initial begin
    int prevS;
    int prevL;
    int holdPort;
    int holdFound;
    bit havePrev;
    repeat (3) @(negedge clk);
    chk("R1 rspValid in reset", int'(rspValid), 0);
    chk("R1 pickPort in reset", int'(pickPort), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rspValid after reset", int'(rspValid), 0);
    chk("R1 pickFound after reset", int'(pickFound), 0);
    chk("R1 pickPort after reset", int'(pickPort), 0);

    // Known case: start 3, ports 3 and 4 failed -> port 1.
    startPort = IW'(3); liveMask = 4'b0011; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R4 wrap example port", int'(pickPort), 1);
    chk("R4 wrap example found", int'(pickFound), 1);
    @(negedge clk);
    chk("R2 no response without request", int'(rspValid), 0);

    // Back-to-back exhaustive sweep.
    havePrev = 0; prevS = 0; prevL = 0;
    for (int s = 0; s < (1 << IW); s++) begin
      for (int l = 0; l < (1 << K); l++) begin
        startPort = IW'(s); liveMask = K'(l); reqValid = 1'b1;
        @(negedge clk);
        checkRsp(s, l);
      end
    end
    reqValid = 1'b0;

    // Gapped requests followed by idle hold with changing inputs.
    for (int s = 1; s <= K; s++) begin
      startPort = IW'(s); liveMask = K'(4'b0001 << (s % K)); reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      checkRsp(s, int'(4'b0001 << (s % K)) & ((1 << K) - 1));
      holdPort = int'(pickPort); holdFound = int'(pickFound);
      for (int c = 0; c < 3; c++) begin
        startPort = IW'(c); liveMask = K'(c * 5 + 3);
        @(negedge clk);
        chk("R8 idle rspValid", int'(rspValid), 0);
        chk("R8 idle pickPort", int'(pickPort), holdPort);
        chk("R8 idle pickFound", int'(pickFound), holdFound);
      end
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule